// File: doc/BRIEF.md
# Interrupt Priority and Trap Unit

This block decides, for a machine with three privilege levels (machine, supervisor, user), whether a trap is due and where it lands. Each cycle it looks at the pending interrupt lines, the delegation masks, the interrupt-enable and previous-state status bits, the current privilege, both trap vector bases, the debug-mode flags and an exception request. From these it works out the winning interrupt, the cause value, the redirect target, the new privilege and the status fields as they must be after the trap is entered.

The decision is combinational, and `trap_pending` tells the pipeline a trap is due. When the pipeline asserts the one-cycle `trap_take` strobe while a trap is pending, every result is registered together. The registered results appear on the outputs one clock later with `out_valid` high for exactly one cycle, and the CSR file and fetch unit use them to update. Exception detection and CSR access decoding happen elsewhere.

Top module: `irq_trap_unit`

## Requirements
- R1: An undelegated pending interrupt (irq_deleg bit clear) is a machine candidate. Machine candidates are enabled when cur_priv is below machine (U=0, S=1), or when cur_priv is machine (3) and st_mie is 1.
- R2: Delegated pending interrupts are looked at only when there is no enabled machine candidate. They are enabled when cur_priv is user, or when cur_priv is supervisor and st_sie is 1. They are never enabled in machine mode.
- R3: While dbg_mode is 1, no interrupt is selected. trap_pending then follows exc_req alone.
- R4: Candidate groups have strict priority: first any bit at index 12 or above, then the external pair (9, 11), then the software pair (1, 3), then the timer pair (5, 7). The lowest set index in the winning group is chosen. Bits 0, 2, 4, 6, 8 and 10 are never selected. An interrupt cause is the index with bit XLEN-1 set.
- R5: A selected interrupt wins over a simultaneous exception request. An exception cause is exc_code with bit XLEN-1 clear.
- R6: A trap goes to supervisor when cur_priv is user or supervisor and the cause index has its bit set in the delegation mask (irq_deleg for interrupts, exc_deleg for exceptions). Otherwise it goes to machine. out_dest encodes 0 machine, 1 supervisor, 2 debug entry, 3 debug redirect.
- R7: On a supervisor trap the new PC is stvec, SPIE takes the old SIE, SPP takes bit 0 of the old privilege, SIE clears, the new privilege is supervisor, and the machine fields pass through.
- R8: On a machine trap the new PC is mtvec with bit 0 cleared. If mtvec bit 0 is 1 and the cause is an interrupt, four times the cause index is added.
- R9: On a machine trap MPIE takes the old MIE, MPP takes the old privilege, MIE clears, the new privilege is machine, and the supervisor fields pass through.
- R10: In debug mode, a breakpoint exception (code 3) goes to DBG_ENTRY (default 0x800) and any other exception goes to DBG_TVEC (default 0x808). Privilege and all status fields stay unchanged.
- R11: Outside debug mode, a breakpoint taken at a privilege whose ebreak-to-debug bit (ebk_u, ebk_s, ebk_m) is set enters debug. The PC becomes DBG_ENTRY, out_dpriv holds the old privilege, out_epc holds cur_pc, the privilege becomes machine and the status fields stay unchanged. With that bit clear the breakpoint is an ordinary trap.
- R12: Results are registered only on a clock edge where trap_take and trap_pending are both high. out_valid is high for exactly the following cycle and is 0 after reset. Without such an edge the result fields hold their values.
- R13: out_epc is cur_pc. out_tval is exc_tval for an exception and zero for an interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_pending | input | XLEN | Pending interrupt lines |
| irq_deleg | input | XLEN | Interrupt delegation mask |
| exc_deleg | input | XLEN | Exception delegation mask |
| st_mie | input | 1 | Machine interrupt enable |
| st_sie | input | 1 | Supervisor interrupt enable |
| st_mpie | input | 1 | Machine previous interrupt enable |
| st_spie | input | 1 | Supervisor previous interrupt enable |
| st_mpp | input | 2 | Machine previous privilege |
| st_spp | input | 1 | Supervisor previous privilege |
| cur_priv | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| stvec | input | XLEN | Supervisor trap vector base |
| mtvec | input | XLEN | Machine trap vector base, bit 0 selects vectoring |
| dbg_mode | input | 1 | Debug mode active |
| ebk_m | input | 1 | Breakpoint in machine mode enters debug |
| ebk_s | input | 1 | Breakpoint in supervisor mode enters debug |
| ebk_u | input | 1 | Breakpoint in user mode enters debug |
| exc_req | input | 1 | Exception request |
| exc_code | input | log2(XLEN) | Exception code |
| exc_tval | input | XLEN | Exception trap value |
| cur_pc | input | XLEN | PC of the trapping instruction |
| trap_take | input | 1 | Commit strobe |
| trap_pending | output | 1 | A trap would be taken now |
| out_valid | output | 1 | Registered result valid, one cycle |
| out_dest | output | 2 | Destination code |
| out_pc | output | XLEN | Redirect PC |
| out_cause | output | XLEN | Cause value |
| out_epc | output | XLEN | Saved PC |
| out_tval | output | XLEN | Trap value |
| out_priv | output | 2 | New privilege |
| out_mie | output | 1 | New MIE |
| out_mpie | output | 1 | New MPIE |
| out_mpp | output | 2 | New MPP |
| out_sie | output | 1 | New SIE |
| out_spie | output | 1 | New SPIE |
| out_spp | output | 1 | New SPP |
| out_dpriv | output | 2 | Privilege saved on debug entry |

## Verification
Interrupt selection is driven with pending vectors that have several groups set at once, with pairs inside one group, and with only unassigned low bits set. These show whether group rank, lowest-index choice and the never-selected bits are handled correctly. Enable and delegation are swept over all three privileges, with each interrupt-enable bit on and off, and with a delegated interrupt of higher group competing against an undelegated one. This separates the machine-first rule from plain group order. Exceptions are tried with and without a competing interrupt, with vectored and direct machine bases, in and out of debug mode, and as breakpoints with each ebreak bit. A long pseudo-random sweep compares every result field with a model written from the requirements.

// File: rtl/irq_trap_pkg.sv
`timescale 1ns/1ps
package irq_trap_pkg;
    // interrupt line indices that the group ranking depends on
    localparam int unsigned IDX_SSI = 1;
    localparam int unsigned IDX_MSI = 3;
    localparam int unsigned IDX_STI = 5;
    localparam int unsigned IDX_MTI = 7;
    localparam int unsigned IDX_SEI = 9;
    localparam int unsigned IDX_MEI = 11;
    localparam int unsigned NUM_GROUPS = 4;

    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    localparam int unsigned BKPT_CODE = 3;

    typedef enum logic [1:0] {
        DEST_M         = 2'd0,
        DEST_S         = 2'd1,
        DEST_DBG_ENTER = 2'd2,
        DEST_DBG_REDIR = 2'd3
    } dest_e;
endpackage

// File: rtl/irq_select.sv
`timescale 1ns/1ps
module irq_select
    import irq_trap_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]         pending,
    input  logic [XLEN-1:0]         deleg,
    input  logic                    mie,
    input  logic                    sie,
    input  logic [1:0]              priv,
    input  logic                    dbg_mode,
    output logic                    hit,
    output logic [$clog2(XLEN)-1:0] code
);
    localparam int CW = $clog2(XLEN);

    // group 0 ranks highest
    function automatic logic [XLEN-1:0] grp_mask(input int g);
        logic [XLEN-1:0] one;
        one = XLEN'(1);
        case (g)
            0:       grp_mask = ~((one << (IDX_MEI + 1)) - one);
            1:       grp_mask = (one << IDX_MEI) | (one << IDX_SEI);
            2:       grp_mask = (one << IDX_MSI) | (one << IDX_SSI);
            default: grp_mask = (one << IDX_MTI) | (one << IDX_STI);
        endcase
    endfunction

    logic            m_en, s_en;
    logic [XLEN-1:0] m_cand, s_cand, cand, win;

    always_comb begin
        m_en   = (priv != PRIV_M) || mie;
        s_en   = (priv == PRIV_U) || ((priv == PRIV_S) && sie);
        m_cand = pending & ~deleg & {XLEN{m_en}};
        s_cand = pending & deleg & {XLEN{s_en}};
        if (dbg_mode)
            cand = '0;
        else if (m_cand != '0)
            cand = m_cand;
        else
            cand = s_cand;

        // walk from lowest rank upward so the highest non-empty group wins
        win = '0;
        for (int g = NUM_GROUPS - 1; g >= 0; g--) begin
            if ((cand & grp_mask(g)) != '0)
                win = cand & grp_mask(g);
        end

        hit  = (win != '0);
        code = '0;
        for (int i = XLEN - 1; i >= 0; i--) begin
            if (win[i])
                code = CW'(i);
        end
    end
endmodule

// File: rtl/trap_route.sv
`timescale 1ns/1ps
module trap_route
    import irq_trap_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter logic [XLEN-1:0] DBG_ENTRY = 'h800,
    parameter logic [XLEN-1:0] DBG_TVEC  = 'h808
) (
    input  logic                    irq_hit,
    input  logic [$clog2(XLEN)-1:0] irq_code,
    input  logic                    exc_req,
    input  logic [$clog2(XLEN)-1:0] exc_code,
    input  logic [XLEN-1:0]         exc_tval,
    input  logic [XLEN-1:0]         cur_pc,
    input  logic [1:0]              priv,
    input  logic [XLEN-1:0]         irq_deleg,
    input  logic [XLEN-1:0]         exc_deleg,
    input  logic                    mie,
    input  logic                    mpie,
    input  logic [1:0]              mpp,
    input  logic                    sie,
    input  logic                    spie,
    input  logic                    spp,
    input  logic [XLEN-1:0]         stvec,
    input  logic [XLEN-1:0]         mtvec,
    input  logic                    dbg_mode,
    input  logic                    ebk_m,
    input  logic                    ebk_s,
    input  logic                    ebk_u,
    output logic                    pend,
    output dest_e                   dest,
    output logic [XLEN-1:0]         new_pc,
    output logic [XLEN-1:0]         cause,
    output logic [XLEN-1:0]         epc,
    output logic [XLEN-1:0]         tval,
    output logic [1:0]              new_priv,
    output logic                    n_mie,
    output logic                    n_mpie,
    output logic [1:0]              n_mpp,
    output logic                    n_sie,
    output logic                    n_spie,
    output logic                    n_spp,
    output logic [1:0]              dpriv
);
    localparam int CW = $clog2(XLEN);

    logic [CW-1:0]   idx;
    logic [XLEN-1:0] dmask;
    logic            to_s, is_bkpt, ebk_hit;
    logic [XLEN-1:0] vec_off;

    always_comb begin
        pend    = irq_hit || exc_req;
        idx     = irq_hit ? irq_code : exc_code;
        cause   = {irq_hit, {(XLEN-1-CW){1'b0}}, idx};
        dmask   = irq_hit ? irq_deleg : exc_deleg;
        to_s    = ((priv == PRIV_U) || (priv == PRIV_S)) && dmask[idx];
        is_bkpt = !irq_hit && (exc_code == CW'(BKPT_CODE));
        ebk_hit = is_bkpt && (((priv == PRIV_M) && ebk_m) ||
                              ((priv == PRIV_S) && ebk_s) ||
                              ((priv == PRIV_U) && ebk_u));
        vec_off = (mtvec[0] && irq_hit) ? (XLEN'(idx) << 2) : '0;

        // pass-through defaults
        epc      = cur_pc;
        tval     = irq_hit ? '0 : exc_tval;
        dpriv    = priv;
        new_priv = priv;
        n_mie    = mie;
        n_mpie   = mpie;
        n_mpp    = mpp;
        n_sie    = sie;
        n_spie   = spie;
        n_spp    = spp;

        if (dbg_mode) begin
            dest   = DEST_DBG_REDIR;
            new_pc = is_bkpt ? DBG_ENTRY : DBG_TVEC;
        end else if (ebk_hit) begin
            dest     = DEST_DBG_ENTER;
            new_pc   = DBG_ENTRY;
            new_priv = PRIV_M;
        end else if (to_s) begin
            dest     = DEST_S;
            new_pc   = stvec;
            n_spie   = sie;
            n_spp    = priv[0];
            n_sie    = 1'b0;
            new_priv = PRIV_S;
        end else begin
            dest     = DEST_M;
            new_pc   = {mtvec[XLEN-1:1], 1'b0} + vec_off;
            n_mpie   = mie;
            n_mpp    = priv;
            n_mie    = 1'b0;
            new_priv = PRIV_M;
        end
    end
endmodule

// File: rtl/irq_trap_unit.sv
`timescale 1ns/1ps
module irq_trap_unit
    import irq_trap_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter logic [XLEN-1:0] DBG_ENTRY = 'h800,
    parameter logic [XLEN-1:0] DBG_TVEC  = 'h808
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [XLEN-1:0]         irq_pending,
    input  logic [XLEN-1:0]         irq_deleg,
    input  logic [XLEN-1:0]         exc_deleg,
    input  logic                    st_mie,
    input  logic                    st_sie,
    input  logic                    st_mpie,
    input  logic                    st_spie,
    input  logic [1:0]              st_mpp,
    input  logic                    st_spp,
    input  logic [1:0]              cur_priv,
    input  logic [XLEN-1:0]         stvec,
    input  logic [XLEN-1:0]         mtvec,
    input  logic                    dbg_mode,
    input  logic                    ebk_m,
    input  logic                    ebk_s,
    input  logic                    ebk_u,
    input  logic                    exc_req,
    input  logic [$clog2(XLEN)-1:0] exc_code,
    input  logic [XLEN-1:0]         exc_tval,
    input  logic [XLEN-1:0]         cur_pc,
    input  logic                    trap_take,
    output logic                    trap_pending,
    output logic                    out_valid,
    output logic [1:0]              out_dest,
    output logic [XLEN-1:0]         out_pc,
    output logic [XLEN-1:0]         out_cause,
    output logic [XLEN-1:0]         out_epc,
    output logic [XLEN-1:0]         out_tval,
    output logic [1:0]              out_priv,
    output logic                    out_mie,
    output logic                    out_mpie,
    output logic [1:0]              out_mpp,
    output logic                    out_sie,
    output logic                    out_spie,
    output logic                    out_spp,
    output logic [1:0]              out_dpriv
);
    localparam int CW = $clog2(XLEN);

    typedef struct packed {
        logic            valid;
        dest_e           dest;
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] cause;
        logic [XLEN-1:0] epc;
        logic [XLEN-1:0] tval;
        logic [1:0]      priv;
        logic            mie;
        logic            mpie;
        logic [1:0]      mpp;
        logic            sie;
        logic            spie;
        logic            spp;
        logic [1:0]      dpriv;
    } result_t;

    logic            irq_hit;
    logic [CW-1:0]   irq_code;
    logic            rt_pend;
    dest_e           rt_dest;
    logic [XLEN-1:0] rt_pc, rt_cause, rt_epc, rt_tval;
    logic [1:0]      rt_priv, rt_mpp, rt_dpriv;
    logic            rt_mie, rt_mpie, rt_sie, rt_spie, rt_spp;

    result_t res_d, res_q;

    irq_select #(.XLEN(XLEN)) u_select (
        .pending  (irq_pending),
        .deleg    (irq_deleg),
        .mie      (st_mie),
        .sie      (st_sie),
        .priv     (cur_priv),
        .dbg_mode (dbg_mode),
        .hit      (irq_hit),
        .code     (irq_code)
    );

    trap_route #(.XLEN(XLEN), .DBG_ENTRY(DBG_ENTRY), .DBG_TVEC(DBG_TVEC)) u_route (
        .irq_hit   (irq_hit),
        .irq_code  (irq_code),
        .exc_req   (exc_req),
        .exc_code  (exc_code),
        .exc_tval  (exc_tval),
        .cur_pc    (cur_pc),
        .priv      (cur_priv),
        .irq_deleg (irq_deleg),
        .exc_deleg (exc_deleg),
        .mie       (st_mie),
        .mpie      (st_mpie),
        .mpp       (st_mpp),
        .sie       (st_sie),
        .spie      (st_spie),
        .spp       (st_spp),
        .stvec     (stvec),
        .mtvec     (mtvec),
        .dbg_mode  (dbg_mode),
        .ebk_m     (ebk_m),
        .ebk_s     (ebk_s),
        .ebk_u     (ebk_u),
        .pend      (rt_pend),
        .dest      (rt_dest),
        .new_pc    (rt_pc),
        .cause     (rt_cause),
        .epc       (rt_epc),
        .tval      (rt_tval),
        .new_priv  (rt_priv),
        .n_mie     (rt_mie),
        .n_mpie    (rt_mpie),
        .n_mpp     (rt_mpp),
        .n_sie     (rt_sie),
        .n_spie    (rt_spie),
        .n_spp     (rt_spp),
        .dpriv     (rt_dpriv)
    );

    assign trap_pending = rt_pend;

    always_comb begin
        res_d       = res_q;
        res_d.valid = 1'b0;
        if (trap_take && rt_pend) begin
            res_d.valid = 1'b1;
            res_d.dest  = rt_dest;
            res_d.pc    = rt_pc;
            res_d.cause = rt_cause;
            res_d.epc   = rt_epc;
            res_d.tval  = rt_tval;
            res_d.priv  = rt_priv;
            res_d.mie   = rt_mie;
            res_d.mpie  = rt_mpie;
            res_d.mpp   = rt_mpp;
            res_d.sie   = rt_sie;
            res_d.spie  = rt_spie;
            res_d.spp   = rt_spp;
            res_d.dpriv = rt_dpriv;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            res_q <= '0;
        else
            res_q <= res_d;
    end

    assign out_valid = res_q.valid;
    assign out_dest  = res_q.dest;
    assign out_pc    = res_q.pc;
    assign out_cause = res_q.cause;
    assign out_epc   = res_q.epc;
    assign out_tval  = res_q.tval;
    assign out_priv  = res_q.priv;
    assign out_mie   = res_q.mie;
    assign out_mpie  = res_q.mpie;
    assign out_mpp   = res_q.mpp;
    assign out_sie   = res_q.sie;
    assign out_spie  = res_q.spie;
    assign out_spp   = res_q.spp;
    assign out_dpriv = res_q.dpriv;

    // selector stays silent in debug mode
    assert_irq_quiet_dbg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_mode |-> !irq_hit);

    // a selected line is actually pending
    assert_irq_is_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_hit |-> irq_pending[irq_code]);

    // interrupt outranks exception in the routed cause
    assert_irq_over_exc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_hit && exc_req) |-> rt_cause[XLEN-1]);

    // registered result only follows a commit strobe
    assert_commit_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(trap_take));

    // supervisor entry closes SIE and lands in S
    assert_s_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_dest == DEST_S) |-> (out_priv == PRIV_S && !out_sie));

    // machine entry closes MIE and lands in M
    assert_m_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_dest == DEST_M) |-> (out_priv == PRIV_M && !out_mie));
endmodule

// File: tb/test_irq_trap_unit.sv
`timescale 1ns/1ps
module test_irq_trap_unit;
    localparam int XLEN = 32;
    localparam logic [31:0] ENTRY = 32'h800;
    localparam logic [31:0] TVEC  = 32'h808;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pend = '0, ideleg = '0, edeleg = '0;
    logic        mie = 0, sie = 0, mpie = 0, spie = 0, spp = 0;
    logic [1:0]  mpp = '0, priv = 2'd3;
    logic [31:0] stv = 32'h0000_4000, mtv = 32'h0000_1000;
    logic        dbg = 0, ebm = 0, ebs = 0, ebu = 0, ereq = 0, take = 0;
    logic [4:0]  ecode = '0;
    logic [31:0] etval = '0, pc = 32'h0000_2468;

    logic        trap_pending, out_valid, out_mie, out_mpie, out_sie, out_spie, out_spp;
    logic [1:0]  out_dest, out_priv, out_mpp, out_dpriv;
    logic [31:0] out_pc, out_cause, out_epc, out_tval;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // expected values
    logic        exp_pending;
    logic [1:0]  exp_dest, exp_priv, exp_mpp, exp_dpriv;
    logic [31:0] exp_pc, exp_cause, exp_epc, exp_tval;
    logic        exp_mie, exp_mpie, exp_sie, exp_spie, exp_spp;

    irq_trap_unit #(.XLEN(XLEN)) i_irq_trap_unit (
        .clk(clk), .rst_n(rst_n),
        .irq_pending(pend), .irq_deleg(ideleg), .exc_deleg(edeleg),
        .st_mie(mie), .st_sie(sie), .st_mpie(mpie), .st_spie(spie),
        .st_mpp(mpp), .st_spp(spp), .cur_priv(priv),
        .stvec(stv), .mtvec(mtv), .dbg_mode(dbg),
        .ebk_m(ebm), .ebk_s(ebs), .ebk_u(ebu),
        .exc_req(ereq), .exc_code(ecode), .exc_tval(etval), .cur_pc(pc),
        .trap_take(take), .trap_pending(trap_pending), .out_valid(out_valid),
        .out_dest(out_dest), .out_pc(out_pc), .out_cause(out_cause),
        .out_epc(out_epc), .out_tval(out_tval), .out_priv(out_priv),
        .out_mie(out_mie), .out_mpie(out_mpie), .out_mpp(out_mpp),
        .out_sie(out_sie), .out_spie(out_spie), .out_spp(out_spp),
        .out_dpriv(out_dpriv)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // model written from the requirement list
    task automatic compute_expected();
        logic men, sen, irq, tos, bk, ebk;
        logic [31:0] c, w, dm;
        int idx;
        men = (priv != 2'd3) || mie;                                  // R1
        c = pend & ~ideleg & {32{men}};
        if (c == 0) begin                                             // R2
            sen = (priv == 2'd0) || (priv == 2'd1 && sie);
            c = pend & ideleg & {32{sen}};
        end
        if (dbg) c = 0;                                               // R3
        if ((c & 32'hFFFF_F000) != 0) w = c & 32'hFFFF_F000;          // R4
        else if ((c & 32'h0000_0A00) != 0) w = c & 32'h0000_0A00;
        else if ((c & 32'h0000_000A) != 0) w = c & 32'h0000_000A;
        else w = c & 32'h0000_00A0;
        irq = (w != 0);
        idx = 0;
        for (int i = 31; i >= 0; i--) if (w[i]) idx = i;
        if (!irq) idx = int'(ecode);
        exp_pending = irq || ereq;                                    // R5
        exp_cause = {irq, 26'd0, 5'(idx)};
        exp_epc = pc;                                                 // R13
        exp_tval = irq ? 32'd0 : etval;
        exp_dpriv = priv;
        exp_priv = priv;
        exp_mie = mie; exp_mpie = mpie; exp_mpp = mpp;
        exp_sie = sie; exp_spie = spie; exp_spp = spp;
        dm = irq ? ideleg : edeleg;
        tos = (priv == 2'd0 || priv == 2'd1) && dm[idx];              // R6
        bk = !irq && ecode == 5'd3;
        ebk = bk && ((priv == 2'd3 && ebm) || (priv == 2'd1 && ebs) || (priv == 2'd0 && ebu));
        if (dbg) begin                                                // R10
            exp_dest = 2'd3;
            exp_pc = bk ? ENTRY : TVEC;
        end else if (ebk) begin                                       // R11
            exp_dest = 2'd2;
            exp_pc = ENTRY;
            exp_priv = 2'd3;
        end else if (tos) begin                                       // R7
            exp_dest = 2'd1;
            exp_pc = stv;
            exp_spie = sie; exp_spp = priv[0]; exp_sie = 1'b0; exp_priv = 2'd1;
        end else begin                                                // R8 R9
            exp_dest = 2'd0;
            exp_pc = {mtv[31:1], 1'b0} + ((mtv[0] && irq) ? 32'(idx) * 4 : 32'd0);
            exp_mpie = mie; exp_mpp = priv; exp_mie = 1'b0; exp_priv = 2'd3;
        end
    endtask

    // called at a negedge; strobes trap_take for one cycle and compares
    task automatic fire(input string req);
        compute_expected();
        #1;
        chk({req, " pending"}, 32'(trap_pending), 32'(exp_pending));
        take = 1'b1;
        @(posedge clk);
        @(negedge clk);
        take = 1'b0;
        chk({req, " valid"}, 32'(out_valid), 32'(exp_pending));
        if (exp_pending) begin
            chk({req, " pc"}, out_pc, exp_pc);
            chk({req, " cause"}, out_cause, exp_cause);
            chk({req, " dest"}, 32'(out_dest), 32'(exp_dest));
            chk({req, " priv"}, 32'(out_priv), 32'(exp_priv));
            chk({req, " status"},
                32'({out_mie, out_mpie, out_mpp, out_sie, out_spie, out_spp}),
                32'({exp_mie, exp_mpie, exp_mpp, exp_sie, exp_spie, exp_spp}));
            chk({req, " epc"}, out_epc, exp_epc);
            chk({req, " tval"}, out_tval, exp_tval);
            chk({req, " dpriv"}, 32'(out_dpriv), 32'(exp_dpriv));
        end
    endtask

    task automatic defaults();
        pend = '0; ideleg = '0; edeleg = '0;
        mie = 0; sie = 0; mpie = 0; spie = 0; spp = 0; mpp = 2'd0; priv = 2'd3;
        stv = 32'h0000_4000; mtv = 32'h0000_1000;
        dbg = 0; ebm = 0; ebs = 0; ebu = 0; ereq = 0; ecode = '0;
        etval = 32'h0000_0BAD; pc = 32'h0000_2468;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R12 reset valid", 32'(out_valid), 32'd0);
        chk("R12 reset pending", 32'(trap_pending), 32'd0);
    endtask

    task automatic t_m_enable();
        defaults();
        pend = 32'h80;
        fire("R1 M mie=0");
        mie = 1;
        fire("R1 M mie=1");
        chk("R1 cause", out_cause, 32'h8000_0007);
        mie = 0; priv = 2'd1;
        fire("R1 below M");
        chk("R1 new priv", 32'(out_priv), 32'd3);
    endtask

    task automatic t_s_path();
        defaults();
        ideleg = 32'h222; pend = 32'h20; priv = 2'd1;
        fire("R2 S sie=0");
        sie = 1;
        fire("R2 S sie=1");
        chk("R2 cause", out_cause, 32'h8000_0005);
        chk("R2 dest", 32'(out_dest), 32'd1);
        chk("R7 pc", out_pc, 32'h0000_4000);
        sie = 0; priv = 2'd0;
        fire("R2 U");
        priv = 2'd3; sie = 1; mie = 1;
        fire("R2 M never");
        priv = 2'd1; mie = 0; pend = 32'h208;
        fire("R1 M cand first");
        chk("R1 M cand first cause", out_cause, 32'h8000_0003);
    endtask

    task automatic t_groups();
        defaults();
        mie = 1;
        pend = 32'h0001_0800; fire("R4 custom");
        chk("R4 custom cause", out_cause, 32'h8000_0010);
        pend = 32'h0010_2000; fire("R4 custom low");
        chk("R4 custom low cause", out_cause, 32'h8000_000D);
        pend = 32'h0000_0A02; fire("R4 external");
        chk("R4 external cause", out_cause, 32'h8000_0009);
        pend = 32'h0000_00A8; fire("R4 software");
        chk("R4 software cause", out_cause, 32'h8000_0003);
        pend = 32'h0000_00A0; fire("R4 timer");
        chk("R4 timer cause", out_cause, 32'h8000_0005);
        pend = 32'h0000_0551; fire("R4 unassigned");
        chk("R4 unassigned pending", 32'(trap_pending), 32'd0);
    endtask

    task automatic t_exc_vs_irq();
        defaults();
        mie = 1; pend = 32'h80; ereq = 1; ecode = 5'd2; etval = 32'h1234_5678;
        fire("R5 irq wins");
        chk("R13 irq tval", out_tval, 32'd0);
        pend = '0;
        fire("R5 exception");
        chk("R13 exc tval", out_tval, 32'h1234_5678);
        chk("R13 epc", out_epc, 32'h0000_2468);
    endtask

    task automatic t_deleg_exc();
        defaults();
        ereq = 1; ecode = 5'd8; edeleg = 32'h100; priv = 2'd0; sie = 1;
        fire("R6 U deleg");
        chk("R7 spie", 32'(out_spie), 32'd1);
        chk("R7 spp", 32'(out_spp), 32'd0);
        priv = 2'd1;
        fire("R7 S deleg");
        chk("R7 spp S", 32'(out_spp), 32'd1);
        priv = 2'd3; mie = 1;
        fire("R6 M ignores deleg");
        chk("R9 mpp", 32'(out_mpp), 32'd3);
        chk("R9 mpie", 32'(out_mpie), 32'd1);
        edeleg = 32'h200; priv = 2'd0;
        fire("R6 bit clear");
        chk("R6 bit clear dest", 32'(out_dest), 32'd0);
    endtask

    task automatic t_vector();
        defaults();
        mtv = 32'h0000_1001; mie = 1; pend = 32'h80;
        fire("R8 vectored");
        chk("R8 vectored pc", out_pc, 32'h0000_101C);
        pend = '0; ereq = 1; ecode = 5'd2;
        fire("R8 vectored exc");
        chk("R8 vectored exc pc", out_pc, 32'h0000_1000);
        mtv = 32'h0000_2000; ereq = 0; pend = 32'h80;
        fire("R8 direct");
        chk("R8 direct pc", out_pc, 32'h0000_2000);
    endtask

    task automatic t_debug();
        defaults();
        dbg = 1; mie = 1; pend = 32'h800;
        fire("R3 masked");
        priv = 2'd1; ereq = 1; ecode = 5'd3;
        fire("R10 bkpt");
        chk("R10 bkpt pc", out_pc, 32'h0000_0800);
        chk("R10 priv kept", 32'(out_priv), 32'd1);
        ecode = 5'd5;
        fire("R10 other");
        chk("R10 other pc", out_pc, 32'h0000_0808);
    endtask

    task automatic t_ebreak();
        defaults();
        priv = 2'd1; ebs = 1; ereq = 1; ecode = 5'd3; pc = 32'h0000_3330;
        fire("R11 enter");
        chk("R11 dest", 32'(out_dest), 32'd2);
        chk("R11 dpriv", 32'(out_dpriv), 32'd1);
        ebs = 0; ebm = 1;
        fire("R11 other level");
        chk("R11 normal dest", 32'(out_dest), 32'd0);
        priv = 2'd0; ebu = 1;
        fire("R11 user");
    endtask

    task automatic t_commit();
        logic [31:0] held;
        defaults();
        fire("R12 nothing");
        mie = 1; pend = 32'h80;
        fire("R12 one trap");
        held = out_pc;
        @(negedge clk);
        chk("R12 pulse ends", 32'(out_valid), 32'd0);
        chk("R12 hold", out_pc, held);
        mtv = 32'h0000_5000;
        @(negedge clk);
        chk("R12 no take", 32'(out_valid), 32'd0);
        chk("R12 no take hold", out_pc, held);
    endtask

    task automatic t_sweep();
        logic [1:0] pv [3] = '{2'd0, 2'd1, 2'd3};
        for (int n = 0; n < 400; n++) begin
            pend   = $urandom & $urandom;
            ideleg = $urandom;
            edeleg = $urandom;
            {mie, sie, mpie, spie, spp} = 5'($urandom);
            mpp    = 2'($urandom);
            priv   = pv[$urandom % 3];
            stv    = $urandom & 32'hFFFF_FFFC;
            mtv    = $urandom;
            dbg    = ($urandom % 8) == 0;
            {ebm, ebs, ebu} = 3'($urandom);
            ereq   = 1'($urandom);
            ecode  = ($urandom % 2) ? 5'd3 : 5'($urandom);
            etval  = $urandom;
            pc     = $urandom;
            fire("R4 R6 R13 sweep");
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        defaults();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_m_enable();
        t_s_path();
        t_groups();
        t_exc_vs_irq();
        t_deleg_exc();
        t_vector();
        t_debug();
        t_ebreak();
        t_commit();
        t_sweep();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule